// File: doc/BRIEF.md
# Packed SIMD Adder with Selectable Lane Linking

This block adds or subtracts two packed 32-bit words built from four 8-bit adder lanes. Between neighbouring lanes a multiplexer picks the carry that enters the upper lane. It takes either the carry-out of the lane below or the lane's own element carry-in. A size selector sets how the lanes group into elements: four 8-bit elements, two 16-bit elements or one 32-bit element. The carry is linked inside each element and broken at element edges.

Four operations are offered: sum, difference, absolute value of the sum and absolute value of the difference. Sum and difference finish in the cycle after start. The two absolute-value operations take a second cycle. The first cycle registers the raw element results. The second cycle passes that stored word through the same lanes again. It inverts each element whose top bit is set and injects a carry-in of 1 at that element's bottom lane. A caller pulses `start` with the operands and reads `result` when `done` pulses.

Top module: `simd_lane_adder`

## Requirements
- R1: While `rstN` is low and in the first cycle after it rises, `result` is 0 and `done` is 0.
- R2: With `sizeSel` = 00 (8-bit), each byte of the result depends only on the same byte of `opA` and `opB`. No carry crosses between bytes.
- R3: With `sizeSel` = 01 (16-bit), the carry out of byte 0 enters byte 1 and the carry out of byte 2 enters byte 3. No carry passes from byte 1 to byte 2.
- R4: With `sizeSel` = 10 or 11 (32-bit), all four bytes form one carry chain.
- R5: `opSel` = 01 (difference) gives A + ~B + 1 per element. `opSel` = 00 gives A + B.
- R6: The carry out of each element's top byte is dropped, so every element result wraps modulo 2^width.
- R7: For `opSel` = 00 or 01, `done` is high in the cycle after the clock edge that samples `start`, and `result` holds the answer in that same cycle.
- R8: For `opSel` = 10 (|A+B|) and 11 (|A-B|), `done` stays low one cycle after start and rises in the next cycle. Each element of `result` is then the two's-complement magnitude of the wrapped sum or difference.
- R9: An element whose raw value is the most negative value (top bit only) keeps that value after the absolute-value step.
- R10: A `start` seen while the second step of an absolute-value operation is pending is ignored. It creates no extra `done` pulse and does not change `result`.
- R11: `done` is a single-cycle pulse per accepted operation. `result` keeps its value in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation with the present operands |
| opSel | input | 2 | 00 sum, 01 difference, 10 abs of sum, 11 abs of difference |
| sizeSel | input | 2 | 00 four 8-bit, 01 two 16-bit, 1x one 32-bit |
| opA | input | 32 | Packed first operand |
| opB | input | 32 | Packed second operand |
| result | output | 32 | Packed registered result |
| done | output | 1 | One-cycle pulse when `result` is new |

## Verification
The bench uses carries that sit right on the lane boundaries, such as 0x00FF plus 1 in 16-bit mode. A wrong link multiplexer would either lose the carry into byte 1 or leak a carry from byte 1 into byte 2. Differences of zero minus one in each mode check that the forced carry-in lands only at element bottoms; otherwise lanes come out off by one. Absolute values of negative, positive and most-negative elements check that the sign is taken from the element's top byte and not from each byte. A second start fired during the pending step checks that the block neither double-pulses `done` nor overwrites the result with the stray operation.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  typedef enum logic [1:0] {
    OP_SUM      = 2'b00,
    OP_DIFF     = 2'b01,
    OP_ABS_SUM  = 2'b10,
    OP_ABS_DIFF = 2'b11
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDirect;  // write adder output straight into result
    logic loadStage;   // write raw adder output into the stage register
    logic loadAbs;     // run the magnitude pass and write result
  } strobe_t;

endpackage

// File: rtl/simd_add_lane.sv
module simd_add_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] laneA,
  input  logic [LANE_W-1:0] laneB,
  input  logic              carryIn,
  output logic [LANE_W-1:0] laneSum,
  output logic              carryOut
);
  logic [LANE_W:0] wideSum;

  always_comb begin
    wideSum  = {1'b0, laneA} + {1'b0, laneB} + {{LANE_W{1'b0}}, carryIn};
    laneSum  = wideSum[LANE_W-1:0];
    carryOut = wideSum[LANE_W];
  end
endmodule

// File: rtl/simd_add_ctrl.sv
module simd_add_ctrl
  import simd_add_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opSel,
  output strobe_t    strobe,
  output logic       opSub,
  output logic       busy,
  output logic       done
);
  logic absPendQ;
  logic doneQ;
  logic accept;

  always_comb begin
    accept            = start & ~absPendQ;
    strobe.loadDirect = accept & ~opSel[1];
    strobe.loadStage  = accept & opSel[1];
    strobe.loadAbs    = absPendQ;
    opSub             = opSel[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      absPendQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      absPendQ <= strobe.loadStage;
      doneQ    <= strobe.loadDirect | strobe.loadAbs;
    end
  end

  assign busy = absPendQ;
  assign done = doneQ;
endmodule

// File: rtl/simd_add_datapath.sv
module simd_add_datapath
  import simd_add_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strobe,
  input  logic                     opSub,
  input  logic [1:0]               sizeSel,
  input  logic [LANE_W*LANES-1:0]  opA,
  input  logic [LANE_W*LANES-1:0]  opB,
  output logic [LANE_W*LANES-1:0]  result
);
  localparam int DW = LANE_W * LANES;

  logic [DW-1:0]    stageQ;
  logic [1:0]       stageSizeQ;
  logic [DW-1:0]    resultQ;
  logic [DW-1:0]    sumVec;
  logic [LANES-1:0] laneCarry;
  logic [1:0]       curSize;
  logic             absStep;

  always_comb begin
    absStep = strobe.loadAbs;
    curSize = absStep ? stageSizeQ : sizeSel;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit IS_ODD   = (i % 2) == 1;
    localparam int PAIR_TOP = ((i | 1) < LANES) ? (i | 1) : i;

    logic [LANE_W-1:0] inA;
    logic [LANE_W-1:0] inB;
    logic              linkIn;
    logic              ownCin;
    logic              negElem;
    logic              cinSel;

    // sign of the element this lane belongs to, taken from the stored word
    always_comb begin
      unique case (curSize)
        2'b00:   negElem = stageQ[i*LANE_W + LANE_W-1];
        2'b01:   negElem = stageQ[PAIR_TOP*LANE_W + LANE_W-1];
        default: negElem = stageQ[DW-1];
      endcase
    end

    always_comb begin
      unique case (curSize)
        2'b00:   linkIn = 1'b0;
        2'b01:   linkIn = IS_ODD;
        default: linkIn = (i != 0);
      endcase
      if (absStep) begin
        inA    = stageQ[i*LANE_W +: LANE_W] ^ {LANE_W{negElem}};
        inB    = '0;
        ownCin = negElem;
      end else begin
        inA    = opA[i*LANE_W +: LANE_W];
        inB    = opB[i*LANE_W +: LANE_W] ^ {LANE_W{opSub}};
        ownCin = opSub;
      end
    end

    if (i == 0) begin : g_first
      assign cinSel = ownCin;
    end else begin : g_linked
      assign cinSel = linkIn ? laneCarry[i-1] : ownCin;
    end

    simd_add_lane #(.LANE_W(LANE_W)) lane_i (
      .laneA   (inA),
      .laneB   (inB),
      .carryIn (cinSel),
      .laneSum (sumVec[i*LANE_W +: LANE_W]),
      .carryOut(laneCarry[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageQ     <= '0;
      stageSizeQ <= 2'b00;
      resultQ    <= '0;
    end else begin
      if (strobe.loadStage) begin
        stageQ     <= sumVec;
        stageSizeQ <= sizeSel;
      end
      if (strobe.loadDirect || strobe.loadAbs) begin
        resultQ <= sumVec;
      end
    end
  end

  assign result = resultQ;
endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_add_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [1:0]              opSel,
  input  logic [1:0]              sizeSel,
  input  logic [LANE_W*LANES-1:0] opA,
  input  logic [LANE_W*LANES-1:0] opB,
  output logic [LANE_W*LANES-1:0] result,
  output logic                    done
);
  strobe_t ctrlStrobe;
  logic    ctrlSub;
  logic    ctrlBusy;

  simd_add_ctrl ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .opSel (opSel),
    .strobe(ctrlStrobe),
    .opSub (ctrlSub),
    .busy  (ctrlBusy),
    .done  (done)
  );

  simd_add_datapath #(.LANE_W(LANE_W), .LANES(LANES)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (ctrlStrobe),
    .opSub  (ctrlSub),
    .sizeSel(sizeSel),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );
endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic [1:0]    opSel,
  input logic [1:0]    sizeSel,
  input logic [DW-1:0] opA,
  input logic [DW-1:0] opB,
  input logic [DW-1:0] result,
  input logic          done,
  input logic          busy
);
  logic pastValid;

  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_DIRECT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !opSel[1]) |=> done); // R7

  AST_ABS_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opSel[1]) |=> (!done ##1 done)); // R8

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (done && !busy)); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !done) |-> $stable(result)); // R11

  AST_BYTE_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opSel == 2'b00 && sizeSel == 2'b00) |=>
      (result[7:0] == 8'($past(opA[7:0]) + $past(opB[7:0])))); // R2

endmodule

bind simd_lane_adder simd_lane_adder_chk #(.DW(LANE_W*LANES)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .opSel  (opSel),
  .sizeSel(sizeSel),
  .opA    (opA),
  .opB    (opB),
  .result (result),
  .done   (done),
  .busy   (ctrlBusy)
);

// File: tb/simd_lane_adder_tb_top.sv
module simd_lane_adder_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [1:0]  sizeSel = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] result;
  logic        done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  simd_lane_adder dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .sizeSel(sizeSel),
    .opA(opA), .opB(opB), .result(result), .done(done)
  );

  function automatic logic [31:0] model(input logic [1:0] op, input logic [1:0] sz,
                                        input logic [31:0] a, input logic [31:0] b);
    int w;
    logic [63:0] m, ea, eb, r, acc;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m = (64'd1 << w) - 1;
    acc = '0;
    for (int e = 0; e < 32 / w; e++) begin
      ea = ({32'd0, a} >> (e * w)) & m;
      eb = ({32'd0, b} >> (e * w)) & m;
      r = op[0] ? (ea - eb) : (ea + eb);
      r = r & m;
      if (op[1] && r[w-1]) r = (~r + 64'd1) & m;
      acc = acc | (r << (e * w));
    end
    return acc[31:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation; checks timing, value, single pulse and hold
  task automatic run_op(input string tag, input logic [1:0] op, input logic [1:0] sz,
                        input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp;
    exp = model(op, sz, a, b);
    @(negedge clk);
    start = 1'b1; opSel = op; sizeSel = sz; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0;
    if (op[1]) begin
      check({tag, " R8 no early done"}, {31'd0, done}, 32'd0);
      @(negedge clk);
    end
    check({tag, " R7/R8 done"}, {31'd0, done}, 32'd1);
    check({tag, " value"}, result, exp);
    @(negedge clk);
    check({tag, " R11 pulse"}, {31'd0, done}, 32'd0);
    check({tag, " R11 hold"}, result, exp);
  endtask

  task automatic t_reset;
    check("R1 result", result, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
  endtask

  task automatic t_bytes;     // R2 R6
    run_op("R2 bytes", 2'b00, 2'b00, 32'hFF01_7F80, 32'h0101_0180);
    check("R2 literal", result, 32'h0002_8000);
  endtask

  task automatic t_halves;    // R3
    run_op("R3 halves", 2'b00, 2'b01, 32'h00FF_00FF, 32'h0001_0001);
    check("R3 literal", result, 32'h0100_0100);
    run_op("R3 R6 wrap", 2'b00, 2'b01, 32'h1234_FFFF, 32'h0000_0001);
    check("R3 R6 literal", result, 32'h1234_0000);
  endtask

  task automatic t_word;      // R4
    run_op("R4 word", 2'b00, 2'b10, 32'h00FF_FFFF, 32'h0000_0001);
    check("R4 literal", result, 32'h0100_0000);
    run_op("R4 size11", 2'b00, 2'b11, 32'hFFFF_FFFF, 32'h0000_0001);
  endtask

  task automatic t_diff;      // R5
    run_op("R5 diff8", 2'b01, 2'b00, 32'h0000_0000, 32'h0101_0101);
    check("R5 diff8 literal", result, 32'hFFFF_FFFF);
    run_op("R5 diff16", 2'b01, 2'b01, 32'h0001_0100, 32'h0000_0001);
    check("R5 diff16 literal", result, 32'h0001_00FF);
    run_op("R5 diff32", 2'b01, 2'b10, 32'h0001_0000, 32'h0000_0001);
    check("R5 diff32 literal", result, 32'h0000_FFFF);
  endtask

  task automatic t_abs;       // R8 R9
    run_op("R8 absdiff8", 2'b11, 2'b00, 32'h0510_0080, 32'h0A05_0100);
    check("R9 absdiff8 literal", result, 32'h050B_0180);
    run_op("R8 abssum16", 2'b10, 2'b01, 32'hFFF0_0010, 32'h0000_0005);
    check("R8 abssum16 literal", result, 32'h0010_0015);
    run_op("R9 absdiff32", 2'b11, 2'b10, 32'h0000_0000, 32'h8000_0000);
    check("R9 absdiff32 literal", result, 32'h8000_0000);
    run_op("R8 absdiff32", 2'b11, 2'b11, 32'h0000_0003, 32'h0000_0100);
  endtask

  task automatic t_ignore;    // R10
    logic [31:0] exp;
    exp = model(2'b11, 2'b00, 32'h0102_0304, 32'h0403_0201);
    @(negedge clk);
    start = 1'b1; opSel = 2'b11; sizeSel = 2'b00; opA = 32'h0102_0304; opB = 32'h0403_0201;
    @(negedge clk);
    opSel = 2'b00; opA = 32'hAAAA_AAAA; opB = 32'h1111_1111;  // stray start, held high
    @(negedge clk);
    start = 1'b0;
    check("R10 done", {31'd0, done}, 32'd1);
    check("R10 value", result, exp);
    @(negedge clk);
    check("R10 no extra done", {31'd0, done}, 32'd0);
    check("R10 result kept", result, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_halves();
    t_word();
    t_diff();
    t_abs();
    t_ignore();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule